// File: doc/BRIEF.md
# Pulse-Pause Reader Bit Transmitter

This block drives a command frame onto one active-high line using pause-width coding. The line normally stays high. Every bit opens with a fixed low pause, and the bit value is carried by how long the line then stays high before the next pause: a one stays high twice as long as a zero. Before each bit goes out, it is XORed with one bit from an external keystream source. The block pulses a strobe once per bit so that the source can step to its next bit.

A frame begins with a start strobe that captures a frame word of up to 32 bits and a 6-bit length. The block first holds the line high for a lead-in wait. It then sends the bits least-significant first and closes the frame with one more pause. A done flag then pulses for one cycle. All durations are counted in protocol ticks of two thirds of a microsecond. A parameter gives the number of clock cycles per tick, so each phase lasts an exact whole number of clock cycles.

Top module: `ppt_pulse_pause_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `line_o` is high and `done_o` and `ks_adv_o` are low.
- R2: A start strobe accepted at a clock edge is followed by exactly 330 ticks (330 × CYCLES_PER_TICK cycles) of high line before the first low level.
- R3: Every bit begins with a low pause of exactly 30 ticks.
- R4: A transmitted one holds the line high for exactly 120 ticks after its pause (150 ticks per bit in total).
- R5: A transmitted zero holds the line high for exactly 60 ticks after its pause (90 ticks per bit in total).
- R6: Bits leave in order from bit 0 to bit n-1 of `frame_i`. Transmitted bit i equals `frame_i[i]` XOR the value on `ks_bit_i` when that bit is captured.
- R7: `ks_adv_o` is high for exactly one cycle per bit, in the first cycle of that bit's pause. `ks_bit_i` is sampled at the clock edge that starts the pause.
- R8: After the last bit, one more low pause of exactly 30 ticks ends the frame, and the line then returns high.
- R9: `done_o` is high for exactly one cycle, the first cycle after the closing pause, and the line is high in that cycle.
- R10: A length of 0 produces only the lead-in wait and the closing pause, with no keystream strobe.
- R11: A length above 32 is treated as 32.
- R12: While a frame is in progress, the start strobe and any change of `frame_i` or `len_i` have no effect on the frame in flight, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| frame_i | input | 32 | Frame word, bit 0 sent first |
| len_i | input | 6 | Number of bits to send (values above 32 clamp to 32) |
| ks_bit_i | input | 1 | Current keystream bit |
| ks_adv_o | output | 1 | One-cycle request to step the keystream |
| line_o | output | 1 | Pulse-pause coded line, idles high |
| done_o | output | 1 | One-cycle frame completion flag |

## Verification
A mixed byte under a partial keystream produces ones and zeros in alternation, which separates the two high widths and shows that the bit order is LSB first. An all-zero keystream applied to a frame of ones and zeros, and an all-one keystream that inverts a short frame, separate the data path from the whitening path. A zero-length frame isolates the lead-in and closing pause. An oversized length exposes the clamp. A start strobe and changed frame inputs arriving mid-frame must leave the recorded waveform identical to that of an undisturbed frame. In every run, the pause and high widths are measured from the line itself, and the position of each strobe and of the done pulse is checked against those widths.

// File: rtl/ppt_pkg.sv
// Shared types and helpers for the pulse-pause transmitter.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package ppt_pkg;

    // Phase of the frame sequencer
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_PAUSE,
        PH_HIGH,
        PH_CLOSE
    } ppt_phase_e;

    // Larger of two integers, used to size tick counters
    function automatic int ppt_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ppt_tick_timer.sv
// Phase timer: counts a loaded number of protocol ticks, each tick lasting
// CPT clock cycles, and flags the last cycle of the interval.
// Assumes: ticks_i is at least 1 whenever load_i is high. A load has
// priority over an expiry in the same cycle, so phases chain back to back.
module ppt_tick_timer #(
    parameter int CPT = 133,
    parameter int TW  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] ticks_i,
    output logic          expire_o
);

    logic          act_q;
    logic [TW-1:0] cnt_q;
    logic          step;

    generate
        if (CPT > 1) begin : g_prescale
            localparam int PW = $clog2(CPT);
            localparam logic [PW-1:0] PRE_TOP = PW'(CPT - 1);
            logic [PW-1:0] pre_q;

            // Cycle prescaler: restarts on load, wraps once per tick
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pre_q <= '0;
                else if (load_i || pre_q == '0)
                    pre_q <= PRE_TOP;
                else
                    pre_q <= pre_q - 1'b1;
            end

            assign step = act_q && (pre_q == '0);
        end else begin : g_direct
            assign step = act_q;
        end
    endgenerate

    // Tick countdown and activity flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (load_i) begin
            act_q <= 1'b1;
            cnt_q <= ticks_i - 1'b1;
        end else if (step) begin
            if (cnt_q == '0)
                act_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = step && (cnt_q == '0);

endmodule

// File: rtl/ppt_bit_pick.sv
// Bit selection and whitening: picks frame bit idx_i, XORs it with the
// keystream bit, and clamps a raw length to the frame width.
// Assumes: MAX_BITS < 2**LEN_W.
module ppt_bit_pick #(
    parameter int MAX_BITS = 32,
    parameter int LEN_W    = 6
) (
    input  logic [MAX_BITS-1:0] frame_i,
    input  logic [LEN_W-1:0]    idx_i,
    input  logic                ks_bit_i,
    input  logic [LEN_W-1:0]    len_raw_i,
    output logic                tx_bit_o,
    output logic [LEN_W-1:0]    nbits_o
);

    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_BITS);

    logic sel;

    // Multiplexer over the frame bits, indices past the frame read zero
    always_comb begin
        sel = 1'b0;
        for (int i = 0; i < MAX_BITS; i++) begin
            if (idx_i == LEN_W'(i))
                sel = frame_i[i];
        end
    end

    assign tx_bit_o = sel ^ ks_bit_i;

    // Length clamp to the frame width
    assign nbits_o = (len_raw_i > LEN_CAP) ? LEN_CAP : len_raw_i;

endmodule

// File: rtl/ppt_frame_seq.sv
// Frame sequencer: walks lead-in, per-bit pause and high phases and the
// closing pause. Drives the line, the keystream strobe and the done flag.
// Assumes: the timer expires in the last cycle of each loaded interval.
// The picked bit is already whitened, and inputs are only taken when idle.
module ppt_frame_seq
    import ppt_pkg::*;
#(
    parameter int MAX_BITS   = 32,
    parameter int LEN_W      = 6,
    parameter int TW         = 9,
    parameter int LEAD_TICKS = 330,
    parameter int PAUSE_TICKS = 30,
    parameter int ONE_TICKS  = 120,
    parameter int ZERO_TICKS = 60
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [MAX_BITS-1:0] frame_i,
    input  logic [LEN_W-1:0]    nbits_i,
    input  logic                pick_bit_i,
    input  logic                expire_i,
    output logic                load_o,
    output logic [TW-1:0]       ticks_o,
    output logic [MAX_BITS-1:0] frame_o,
    output logic [LEN_W-1:0]    idx_o,
    output logic                line_o,
    output logic                ks_adv_o,
    output logic                done_o,
    output logic                busy_o
);

    ppt_phase_e          ph_q, ph_d;
    logic [MAX_BITS-1:0] frame_q;
    logic [LEN_W-1:0]    nbits_q;
    logic [LEN_W-1:0]    idx_q;
    logic                txbit_q;
    logic                adv_q;
    logic                done_q;
    logic                line_q;
    logic                accept;
    logic                capture;
    logic                finish;

    // Next phase, timer load and per-bit capture decisions
    always_comb begin
        ph_d    = ph_q;
        load_o  = 1'b0;
        ticks_o = '0;
        accept  = 1'b0;
        capture = 1'b0;
        finish  = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (start_i) begin
                    accept  = 1'b1;
                    ph_d    = PH_LEAD;
                    load_o  = 1'b1;
                    ticks_o = TW'(LEAD_TICKS);
                end
            end
            PH_LEAD: begin
                if (expire_i) begin
                    load_o  = 1'b1;
                    ticks_o = TW'(PAUSE_TICKS);
                    if (nbits_q == '0) begin
                        ph_d = PH_CLOSE;
                    end else begin
                        ph_d    = PH_PAUSE;
                        capture = 1'b1;
                    end
                end
            end
            PH_PAUSE: begin
                if (expire_i) begin
                    ph_d    = PH_HIGH;
                    load_o  = 1'b1;
                    ticks_o = txbit_q ? TW'(ONE_TICKS) : TW'(ZERO_TICKS);
                end
            end
            PH_HIGH: begin
                if (expire_i) begin
                    load_o  = 1'b1;
                    ticks_o = TW'(PAUSE_TICKS);
                    if (idx_q == nbits_q) begin
                        ph_d = PH_CLOSE;
                    end else begin
                        ph_d    = PH_PAUSE;
                        capture = 1'b1;
                    end
                end
            end
            PH_CLOSE: begin
                if (expire_i) begin
                    ph_d   = PH_IDLE;
                    finish = 1'b1;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase register and registered line, strobe and done outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            line_q <= 1'b1;
            adv_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            line_q <= !(ph_d == PH_PAUSE || ph_d == PH_CLOSE);
            adv_q  <= capture;
            done_q <= finish;
        end
    end

    // Frame capture on accept, bit capture and index step per bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            nbits_q <= '0;
            idx_q   <= '0;
            txbit_q <= 1'b0;
        end else if (accept) begin
            frame_q <= frame_i;
            nbits_q <= nbits_i;
            idx_q   <= '0;
        end else if (capture) begin
            txbit_q <= pick_bit_i;
            idx_q   <= idx_q + 1'b1;
        end
    end

    assign frame_o  = frame_q;
    assign idx_o    = idx_q;
    assign line_o   = line_q;
    assign ks_adv_o = adv_q;
    assign done_o   = done_q;
    assign busy_o   = (ph_q != PH_IDLE);

endmodule

// File: rtl/ppt_pulse_pause_tx.sv
// Top of the pulse-pause transmitter: ties the sequencer, the phase timer
// and the bit picker together.
// Assumes: CYCLES_PER_TICK clock cycles make one protocol tick, and the
// keystream source steps once per ks_adv_o pulse, before the next bit.
module ppt_pulse_pause_tx
    import ppt_pkg::*;
#(
    parameter int MAX_BITS        = 32,
    parameter int LEN_W           = 6,
    parameter int CYCLES_PER_TICK = 133,
    parameter int LEAD_TICKS      = 330,
    parameter int PAUSE_TICKS     = 30,
    parameter int ONE_TICKS       = 120,
    parameter int ZERO_TICKS      = 60
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [MAX_BITS-1:0] frame_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic                ks_bit_i,
    output logic                ks_adv_o,
    output logic                line_o,
    output logic                done_o
);

    localparam int MAX_TICKS = ppt_max(ppt_max(LEAD_TICKS, PAUSE_TICKS),
                                       ppt_max(ONE_TICKS, ZERO_TICKS));
    localparam int TW = $clog2(MAX_TICKS + 1);

    logic                load;
    logic [TW-1:0]       ticks;
    logic                expire;
    logic [MAX_BITS-1:0] frame_q;
    logic [LEN_W-1:0]    idx;
    logic                pick_bit;
    logic [LEN_W-1:0]    nbits;
    logic                busy;

    ppt_bit_pick #(
        .MAX_BITS (MAX_BITS),
        .LEN_W    (LEN_W)
    ) u_pick (
        .frame_i   (frame_q),
        .idx_i     (idx),
        .ks_bit_i  (ks_bit_i),
        .len_raw_i (len_i),
        .tx_bit_o  (pick_bit),
        .nbits_o   (nbits)
    );

    ppt_tick_timer #(
        .CPT (CYCLES_PER_TICK),
        .TW  (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .ticks_i  (ticks),
        .expire_o (expire)
    );

    ppt_frame_seq #(
        .MAX_BITS    (MAX_BITS),
        .LEN_W       (LEN_W),
        .TW          (TW),
        .LEAD_TICKS  (LEAD_TICKS),
        .PAUSE_TICKS (PAUSE_TICKS),
        .ONE_TICKS   (ONE_TICKS),
        .ZERO_TICKS  (ZERO_TICKS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .frame_i    (frame_i),
        .nbits_i    (nbits),
        .pick_bit_i (pick_bit),
        .expire_i   (expire),
        .load_o     (load),
        .ticks_o    (ticks),
        .frame_o    (frame_q),
        .idx_o      (idx),
        .line_o     (line_o),
        .ks_adv_o   (ks_adv_o),
        .done_o     (done_o),
        .busy_o     (busy)
    );

endmodule

// File: rtl/ppt_tx_checker.sv
// Property checker for the pulse-pause transmitter, bound to the top.
// Assumes: PAUSE_CYC equals the pause length in clock cycles.
module ppt_tx_checker #(
    parameter int PAUSE_CYC = 3990
) (
    input logic clk,
    input logic rst_n,
    input logic line_o,
    input logic done_o,
    input logic ks_adv_o,
    input logic busy
);

    int unsigned low_run;

    // Length of the current low stretch of the line
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= 0;
        else if (!line_o)
            low_run <= low_run + 1;
        else
            low_run <= 0;
    end

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !done_o |-> line_o && !ks_adv_o);

    // R3
    pause_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_o) |-> low_run == PAUSE_CYC);

    // R7
    adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ks_adv_o |=> !ks_adv_o);

    // R7
    adv_in_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ks_adv_o |-> !line_o && $rose(!line_o) && busy);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_after_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> line_o && !busy && $rose(line_o));

    // R2
    lead_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> line_o);

endmodule

bind ppt_pulse_pause_tx ppt_tx_checker #(
    .PAUSE_CYC (PAUSE_TICKS * CYCLES_PER_TICK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_o   (line_o),
    .done_o   (done_o),
    .ks_adv_o (ks_adv_o),
    .busy     (busy)
);

// File: tb/tb_ppt_pulse_pause_tx.sv
// Directed bench: records the line, strobe and done per cycle for each
// frame and measures run widths against values derived from the spec.
module tb_ppt_pulse_pause_tx;

    localparam int CPT     = 2;
    localparam int LEAD_C  = 330 * CPT;
    localparam int PAUSE_C = 30 * CPT;
    localparam int ONE_C   = 120 * CPT;
    localparam int ZERO_C  = 60 * CPT;
    localparam int REC_MAX = 16000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] frame_i = '0;
    logic [5:0]  len_i = '0;
    logic        ks_bit;
    logic        ks_adv_o, line_o, done_o;

    logic [31:0] ks_word = '0;
    int          ks_idx = 0;

    int nchk = 0;
    int nbad = 0;

    bit line_a [REC_MAX];
    bit done_a [REC_MAX];
    bit adv_a  [REC_MAX];
    int nrec;

    int run_lvl   [80];
    int run_len   [80];
    int run_start [80];
    int nruns;
    int last_adv_cnt;
    int last_done_cnt;

    always #2.5 clk = ~clk;

    ppt_pulse_pause_tx #(.CYCLES_PER_TICK(CPT)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .frame_i  (frame_i),
        .len_i    (len_i),
        .ks_bit_i (ks_bit),
        .ks_adv_o (ks_adv_o),
        .line_o   (line_o),
        .done_o   (done_o)
    );

    // Keystream source model: steps on each advance strobe
    always @(posedge clk) if (ks_adv_o) ks_idx <= ks_idx + 1;
    assign ks_bit = (ks_idx < 32) ? ks_word[ks_idx] : 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
    endtask

    // Sends one frame, records it, and checks widths, order, strobes, done
    task automatic run_frame(input logic [31:0] fr, input logic [5:0] ln,
                             input logic [31:0] ks, input bit inject);
        int nb;
        int k;
        int done_k;
        logic [31:0] expw, gotw;
        nb = (ln > 32) ? 32 : int'(ln);
        @(negedge clk);
        chk(line_o && !done_o && !ks_adv_o, "R1", "idle before frame", int'(line_o), 1);
        ks_word = ks;
        ks_idx  = 0;
        frame_i = fr;
        len_i   = ln;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 0;
        done_k = -1;
        while (k < REC_MAX) begin
            line_a[k] = line_o;
            done_a[k] = done_o;
            adv_a[k]  = ks_adv_o;
            if (done_o && done_k < 0) done_k = k;
            if (inject && k == 100) begin
                start_i = 1'b1;
                frame_i = ~fr;
                len_i   = 6'd3;
            end
            if (inject && k == 101) start_i = 1'b0;
            k++;
            if (done_k >= 0 && k > done_k + 2) break;
            @(negedge clk);
        end
        nrec = k;
        // split into runs of equal line level
        nruns = 0;
        for (int i = 0; i < nrec; i++) begin
            if (i == 0 || line_a[i] != line_a[i-1]) begin
                if (nruns < 80) begin
                    run_lvl[nruns] = int'(line_a[i]);
                    run_start[nruns] = i;
                    run_len[nruns] = 0;
                end
                nruns++;
            end
            if (nruns <= 80) run_len[nruns-1]++;
        end
        last_adv_cnt = 0;
        last_done_cnt = 0;
        for (int i = 0; i < nrec; i++) begin
            if (adv_a[i]) last_adv_cnt++;
            if (done_a[i]) last_done_cnt++;
        end
        chk(nruns == 2 * nb + 3, "R6", "run count", nruns, 2 * nb + 3);
        if (nruns != 2 * nb + 3) return;
        // R2 lead-in
        chk(run_lvl[0] == 1 && run_len[0] == LEAD_C, "R2", "lead width", run_len[0], LEAD_C);
        expw = '0;
        gotw = '0;
        for (int i = 0; i < nb; i++) begin
            bit e;
            e = fr[i] ^ ks[i];
            expw[i] = e;
            gotw[i] = (run_len[2 + 2*i] == ONE_C);
            chk(run_lvl[1 + 2*i] == 0 && run_len[1 + 2*i] == PAUSE_C, "R3",
                $sformatf("pause width bit %0d", i), run_len[1 + 2*i], PAUSE_C);
            if (e)
                chk(run_len[2 + 2*i] == ONE_C, "R4", $sformatf("one width bit %0d", i),
                    run_len[2 + 2*i], ONE_C);
            else
                chk(run_len[2 + 2*i] == ZERO_C, "R5", $sformatf("zero width bit %0d", i),
                    run_len[2 + 2*i], ZERO_C);
            chk(adv_a[run_start[1 + 2*i]] == 1'b1, "R7",
                $sformatf("strobe at pause start bit %0d", i), int'(adv_a[run_start[1 + 2*i]]), 1);
        end
        chk(gotw == expw, "R6", "whitened LSB-first word", int'(gotw), int'(expw));
        chk(last_adv_cnt == nb, "R7", "strobe count", last_adv_cnt, nb);
        chk(run_lvl[2*nb + 1] == 0 && run_len[2*nb + 1] == PAUSE_C, "R8", "closing pause",
            run_len[2*nb + 1], PAUSE_C);
        chk(done_k == run_start[2*nb + 2] && last_done_cnt == 1, "R9", "done position",
            done_k, run_start[2*nb + 2]);
    endtask

    // Scenario: mixed byte with a partial keystream
    task automatic t_mixed();
        run_frame(32'h0000_00A5, 6'd8, 32'h0000_000F, 1'b0);
    endtask

    // Scenario: full-width frame, keystream zero, data passes unchanged
    task automatic t_plain_full();
        run_frame(32'hC3A5_0F96, 6'd32, 32'h0, 1'b0);
        chk(last_adv_cnt == 32, "R6", "full frame strobes", last_adv_cnt, 32);
    endtask

    // Scenario: keystream all ones inverts a short frame
    task automatic t_inverted();
        run_frame(32'h0000_0013, 6'd5, 32'hFFFF_FFFF, 1'b0);
    endtask

    // Scenario: zero-length frame
    task automatic t_empty();
        run_frame(32'hFFFF_FFFF, 6'd0, 32'h0, 1'b0);
        chk(nruns == 3 && last_adv_cnt == 0, "R10", "empty frame shape", nruns, 3);
    endtask

    // Scenario: oversized length is clamped to 32
    task automatic t_clamp();
        run_frame(32'h1234_5678, 6'd45, 32'h0F0F_F0F0, 1'b0);
        chk(last_adv_cnt == 32, "R11", "clamped strobe count", last_adv_cnt, 32);
    endtask

    // Scenario: start and new inputs while busy are ignored
    task automatic t_busy_start();
        int extra;
        run_frame(32'h0000_0259, 6'd10, 32'h0000_0155, 1'b1);
        chk(last_done_cnt == 1 && last_adv_cnt == 10, "R12", "frame unaffected",
            last_adv_cnt, 10);
        extra = 0;
        repeat (LEAD_C + 200) begin
            @(negedge clk);
            if (!line_o || done_o || ks_adv_o) extra++;
        end
        chk(extra == 0, "R12", "no second frame", extra, 0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(line_o == 1'b1, "R1", "reset line", int'(line_o), 1);
        chk(done_o == 1'b0, "R1", "reset done", int'(done_o), 0);
        chk(ks_adv_o == 1'b0, "R1", "reset strobe", int'(ks_adv_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_mixed();
        t_plain_full();
        t_inverted();
        t_empty();
        t_clamp();
        t_busy_start();
        @(negedge clk);
        chk(line_o && !done_o, "R1", "idle after frames", int'(line_o), 1);
        summary();
        $finish;
    end

endmodule